// File: doc/BRIEF.md
# Wiper Position Counter with Pulse Stepping

This block holds the tap position of one digitally controlled resistor divider. The position is a 6-bit volatile register. It can be loaded in four ways:

- a direct write of a 6-bit value;
- a parallel copy from one of four stored settings;
- a recall of stored setting 0, used at power-up;
- single steps up or down.

The position drives a 64-bit one-hot tap select. Bit 0 connects the wiper to the low-end terminal and bit 63 connects it to the high-end terminal.

Stepping is armed by a level flag. While the flag is high, every rising edge of the sampled serial clock counts as one clock-high pulse. Each pulse moves the position by one, in the direction given by the sampled data-line level on that edge. The surrounding bus logic drops the flag when it sees a stop condition. There is no limit on the number of pulses while the flag is high.

Top module: `wiper_pos_ctrl`

## Requirements
- R1: While `rst_n` is low and after its release, `pos_o` is 0 and `tap_sel_o` equals 64'h1.
- R2: `tap_sel_o` always has exactly one bit set, and that bit's index equals `pos_o`. Index 0 is the low-end terminal and index 63 is the high-end terminal.
- R3: When `wr_i` is high and no higher-priority source is active, `pos_o` equals `wr_dat_i` after the next clock edge.
- R4: When `ld_i` is high and `recall_i` is low, `pos_o` takes setting k after the next clock edge, where k = `ld_sel_i`. Setting k occupies bits 6k+5..6k of `set_dat_i`.
- R5: When `recall_i` is high, `pos_o` takes setting 0 (bits 5..0 of `set_dat_i`) after the next clock edge, whatever the value of `ld_sel_i`.
- R6: When `step_en_i` is high and `scl_i` is sampled high after being low on the previous edge, with `sda_i` high and no load active, `pos_o` increases by one.
- R7: The same pulse with `sda_i` low decreases `pos_o` by one.
- R8: An up step at 63 leaves `pos_o` at 63, and a down step at 0 leaves it at 0. The count saturates and does not wrap.
- R9: A step needs a new low-to-high change of `scl_i`, so holding `scl_i` high gives only one step. Pulses with `step_en_i` low leave `pos_o` unchanged. Any number of pulses may follow one another while `step_en_i` stays high.
- R10: When several sources are active in the same cycle, only the first in this order acts: recall, then parallel load, then direct write, then step. The sources below it have no effect in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| recall_i | input | 1 | Recall stored setting 0 |
| ld_i | input | 1 | Parallel load from a stored setting |
| ld_sel_i | input | 2 | Index of the stored setting to load |
| set_dat_i | input | 24 | Four stored 6-bit settings, setting k at bits 6k+5..6k |
| wr_i | input | 1 | Direct write strobe |
| wr_dat_i | input | 6 | Direct write value |
| step_en_i | input | 1 | Stepping armed |
| scl_i | input | 1 | Sampled serial clock level |
| sda_i | input | 1 | Sampled serial data level (1 = up, 0 = down) |
| pos_o | output | 6 | Current position |
| tap_sel_o | output | 64 | One-hot tap select |

## Verification
A step pulse can arrive in the same cycle as a load. The bench provokes this by raising `scl_i` on the cycle where it also asserts a direct write, a parallel load or a recall. It expects the load value with no step applied. It then checks that the pulse that was used up does not step again on the next cycle while `scl_i` stays high. Recall together with a parallel load pointing at a different setting is judged the same way: setting 0 must win.

// File: rtl/wpc_pkg.sv
package wpc_pkg;
   typedef enum logic [2:0] {
      SRC_HOLD   = 3'd0,
      SRC_RECALL = 3'd1,
      SRC_PAR    = 3'd2,
      SRC_SER    = 3'd3,
      SRC_UP     = 3'd4,
      SRC_DOWN   = 3'd5
   } src_e;
endpackage

// File: rtl/wpc_step_det.sv
module wpc_step_det (
   input  logic clk,
   input  logic rst_n,
   input  logic step_en,
   input  logic scl,
   input  logic sda,
   output logic step_up,
   output logic step_dn
);
   logic scl_q;
   logic rise;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) scl_q <= 1'b0;
      else        scl_q <= scl;
   end

   assign rise    = scl & ~scl_q;
   assign step_up = step_en & rise & sda;
   assign step_dn = step_en & rise & ~sda;
endmodule

// File: rtl/wpc_src_arb.sv
module wpc_src_arb
   import wpc_pkg::*;
(
   input  logic recall,
   input  logic par_ld,
   input  logic ser_wr,
   input  logic step_up,
   input  logic step_dn,
   output src_e src
);
   always_comb begin
      if (recall)       src = SRC_RECALL;
      else if (par_ld)  src = SRC_PAR;
      else if (ser_wr)  src = SRC_SER;
      else if (step_up) src = SRC_UP;
      else if (step_dn) src = SRC_DOWN;
      else              src = SRC_HOLD;
   end
endmodule

// File: rtl/wpc_pos_reg.sv
module wpc_pos_reg
   import wpc_pkg::*;
#(
   parameter int POS_W    = 6,
   parameter int NUM_DR   = 4,
   parameter bit SATURATE = 1'b1,
   parameter int RST_POS  = 0,
   localparam int SEL_W   = $clog2(NUM_DR),
   localparam int BUS_W   = POS_W * NUM_DR
) (
   input  logic             clk,
   input  logic             rst_n,
   input  src_e             src,
   input  logic [SEL_W-1:0] sel,
   input  logic [BUS_W-1:0] set_dat,
   input  logic [POS_W-1:0] wr_dat,
   output logic [POS_W-1:0] pos
);
   localparam logic [POS_W-1:0] TOP = '1;
   localparam logic [POS_W-1:0] BOT = '0;
   localparam logic [POS_W-1:0] ONE = POS_W'(1);

   logic [POS_W-1:0] slice [NUM_DR];
   logic [POS_W-1:0] up_v, dn_v, nxt;

   for (genvar k = 0; k < NUM_DR; k++) begin : g_slice
      assign slice[k] = set_dat[k*POS_W +: POS_W];
   end

   if (SATURATE) begin : g_sat
      assign up_v = (pos == TOP) ? pos : pos + ONE;
      assign dn_v = (pos == BOT) ? pos : pos - ONE;
   end else begin : g_wrap
      assign up_v = pos + ONE;
      assign dn_v = pos - ONE;
   end

   always_comb begin
      unique case (src)
         SRC_RECALL: nxt = slice[0];
         SRC_PAR:    nxt = slice[sel];
         SRC_SER:    nxt = wr_dat;
         SRC_UP:     nxt = up_v;
         SRC_DOWN:   nxt = dn_v;
         default:    nxt = pos;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pos <= POS_W'(RST_POS);
      else        pos <= nxt;
   end
endmodule

// File: rtl/wpc_tap_dec.sv
module wpc_tap_dec #(
   parameter int POS_W = 6,
   localparam int TAPS = 1 << POS_W
) (
   input  logic [POS_W-1:0] pos,
   output logic [TAPS-1:0]  sel
);
   for (genvar i = 0; i < TAPS; i++) begin : g_tap
      assign sel[i] = (pos == POS_W'(i));
   end
endmodule

// File: rtl/wiper_pos_ctrl.sv
module wiper_pos_ctrl
   import wpc_pkg::*;
#(
   parameter int POS_W    = 6,
   parameter int NUM_DR   = 4,
   parameter bit SATURATE = 1'b1,
   parameter bit DEC_REG  = 1'b0,
   localparam int SEL_W   = $clog2(NUM_DR),
   localparam int BUS_W   = POS_W * NUM_DR,
   localparam int TAPS    = 1 << POS_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             recall_i,
   input  logic             ld_i,
   input  logic [SEL_W-1:0] ld_sel_i,
   input  logic [BUS_W-1:0] set_dat_i,
   input  logic             wr_i,
   input  logic [POS_W-1:0] wr_dat_i,
   input  logic             step_en_i,
   input  logic             scl_i,
   input  logic             sda_i,
   output logic [POS_W-1:0] pos_o,
   output logic [TAPS-1:0]  tap_sel_o
);
   initial begin
      assert (POS_W >= 2 && POS_W <= 10)
         else $error("wiper_pos_ctrl: POS_W out of range");
      assert (NUM_DR >= 2 && NUM_DR <= 16)
         else $error("wiper_pos_ctrl: NUM_DR out of range");
   end

   logic            up_w, dn_w;
   src_e            src_w;
   logic [TAPS-1:0] dec_w;

   wpc_step_det u_step (
      .clk(clk), .rst_n(rst_n), .step_en(step_en_i),
      .scl(scl_i), .sda(sda_i), .step_up(up_w), .step_dn(dn_w)
   );

   wpc_src_arb u_arb (
      .recall(recall_i), .par_ld(ld_i), .ser_wr(wr_i),
      .step_up(up_w), .step_dn(dn_w), .src(src_w)
   );

   wpc_pos_reg #(.POS_W(POS_W), .NUM_DR(NUM_DR), .SATURATE(SATURATE)) u_pos (
      .clk(clk), .rst_n(rst_n), .src(src_w), .sel(ld_sel_i),
      .set_dat(set_dat_i), .wr_dat(wr_dat_i), .pos(pos_o)
   );

   wpc_tap_dec #(.POS_W(POS_W)) u_dec (.pos(pos_o), .sel(dec_w));

   if (DEC_REG) begin : g_dec_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) tap_sel_o <= TAPS'(1);
         else        tap_sel_o <= dec_w;
      end
   end else begin : g_dec_comb
      assign tap_sel_o = dec_w;
   end
endmodule

// File: rtl/wiper_pos_ctrl_chk.sv
module wiper_pos_ctrl_chk #(
   parameter int POS_W = 6,
   localparam int TAPS = 1 << POS_W
) (
   input logic             clk,
   input logic             rst_n,
   input logic             recall_i,
   input logic             ld_i,
   input logic             wr_i,
   input logic [POS_W-1:0] wr_dat_i,
   input logic [POS_W-1:0] set0_i,
   input logic             step_en_i,
   input logic             scl_i,
   input logic             sda_i,
   input logic [POS_W-1:0] pos_o,
   input logic [TAPS-1:0]  tap_sel_o
);
   logic scl_seen;
   logic no_ld;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) scl_seen <= 1'b0;
      else        scl_seen <= scl_i;
   end

   assign no_ld = !recall_i && !ld_i && !wr_i;

   AST_ONE_TAP: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(tap_sel_o) == 1); // R2

   AST_RECALL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      recall_i |=> pos_o == $past(set0_i)); // R5

   AST_WRITE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && !recall_i && !ld_i) |=> pos_o == $past(wr_dat_i)); // R3

   AST_UNARMED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (no_ld && !step_en_i) |=> $stable(pos_o)); // R9

   AST_STEP_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
      (no_ld && step_en_i && scl_i && !scl_seen && sda_i && pos_o != '1)
      |=> pos_o == $past(pos_o) + POS_W'(1)); // R6

   AST_TOP_SAT: assert property (@(posedge clk) disable iff (!rst_n)
      (no_ld && step_en_i && scl_i && !scl_seen && sda_i && pos_o == '1)
      |=> pos_o == '1); // R8

   AST_BOT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
      (no_ld && step_en_i && scl_i && !scl_seen && !sda_i && pos_o == '0)
      |=> pos_o == '0); // R8
endmodule

bind wiper_pos_ctrl wiper_pos_ctrl_chk #(.POS_W(POS_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .recall_i(recall_i), .ld_i(ld_i), .wr_i(wr_i),
   .wr_dat_i(wr_dat_i), .set0_i(set_dat_i[POS_W-1:0]), .step_en_i(step_en_i),
   .scl_i(scl_i), .sda_i(sda_i), .pos_o(pos_o), .tap_sel_o(tap_sel_o)
);

// File: tb/wiper_pos_ctrl_test.sv
`timescale 1ns/1ps
module wiper_pos_ctrl_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        recall_i = 1'b0, ld_i = 1'b0, wr_i = 1'b0;
   logic [1:0]  ld_sel_i = '0;
   logic [23:0] set_dat_i;
   logic [5:0]  wr_dat_i = '0;
   logic        step_en_i = 1'b0, scl_i = 1'b0, sda_i = 1'b0;
   logic [5:0]  pos_o;
   logic [63:0] tap_sel_o;

   int checks = 0;
   int errors = 0;
   int m = 0;
   bit scl_prev = 1'b0;
   bit done = 1'b0;
   int dr [4] = '{10, 21, 42, 55};

   logic [5:0] expq [$];
   string      tagq [$];

   always #2.5 clk = ~clk;

   assign set_dat_i = {6'(dr[3]), 6'(dr[2]), 6'(dr[1]), 6'(dr[0])};

   wiper_pos_ctrl uut (
      .clk(clk), .rst_n(rst_n), .recall_i(recall_i), .ld_i(ld_i),
      .ld_sel_i(ld_sel_i), .set_dat_i(set_dat_i), .wr_i(wr_i),
      .wr_dat_i(wr_dat_i), .step_en_i(step_en_i), .scl_i(scl_i),
      .sda_i(sda_i), .pos_o(pos_o), .tap_sel_o(tap_sel_o)
   );

   task automatic op(input bit rc, input bit pl, input int sel, input bit sw,
                     input int sd, input bit en, input bit c, input bit d,
                     input string tag);
      @(negedge clk);
      recall_i = rc; ld_i = pl; ld_sel_i = 2'(sel); wr_i = sw;
      wr_dat_i = 6'(sd); step_en_i = en; scl_i = c; sda_i = d;
      if (rc)      m = dr[0];
      else if (pl) m = dr[sel];
      else if (sw) m = sd;
      else if (en && c && !scl_prev) m = d ? ((m == 63) ? 63 : m + 1)
                                           : ((m == 0) ? 0 : m - 1);
      scl_prev = c;
      expq.push_back(6'(m));
      tagq.push_back(tag);
   endtask

   always @(posedge clk) begin
      #1;
      if (expq.size() > 0) begin
         logic [5:0] e;
         string t;
         e = expq.pop_front();
         t = tagq.pop_front();
         checks++;
         if (pos_o !== e || tap_sel_o !== (64'd1 << e)) begin
            errors++;
            $display("FAIL %s: pos=%0d tap=%h expected pos=%0d tap=%h",
                     t, pos_o, tap_sel_o, e, 64'd1 << e);
         end
      end
   end

   initial begin
      #1000000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run hung, actual=timeout expected=finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      checks++;
      if (pos_o !== 6'd0 || tap_sel_o !== 64'h1) begin
         errors++;
         $display("FAIL R1: pos=%0d tap=%h expected pos=0 tap=1", pos_o, tap_sel_o);
      end
      @(negedge clk);
      rst_n = 1'b1;
      op(0,0,0,0,0,0,0,0,"R1 after reset");
      op(0,0,0,1,37,0,0,0,"R3 direct write 37");
      op(0,0,0,1,5,0,0,0,"R3 direct write 5");
      for (int k = 0; k < 4; k++) op(0,1,k,0,0,0,0,0,"R4 parallel load");
      op(1,0,2,0,0,0,0,0,"R5 recall ignores select");
      op(0,0,0,0,0,1,1,1,"R6 step up");
      op(0,0,0,0,0,1,1,1,"R9 scl held high no second step");
      op(0,0,0,0,0,1,0,1,"R6 scl low");
      op(0,0,0,0,0,1,1,1,"R6 step up again");
      op(0,0,0,0,0,1,0,0,"R7 scl low");
      op(0,0,0,0,0,1,1,0,"R7 step down");
      op(0,0,0,0,0,0,0,0,"R9 idle");
      op(0,0,0,0,0,0,1,1,"R9 unarmed pulse ignored");
      op(0,0,0,0,0,0,0,0,"R9 unarmed low");
      op(0,0,0,0,0,0,1,0,"R9 unarmed pulse down ignored");
      op(0,0,0,1,60,0,0,0,"R3 write 60");
      for (int k = 0; k < 6; k++) begin
         op(0,0,0,0,0,1,1,1,"R8 step up toward top");
         op(0,0,0,0,0,1,0,1,"R8 low phase");
      end
      op(0,0,0,1,2,0,0,0,"R3 write 2");
      for (int k = 0; k < 5; k++) begin
         op(0,0,0,0,0,1,1,0,"R8 step down toward bottom");
         op(0,0,0,0,0,1,0,0,"R8 low phase");
      end
      for (int k = 0; k < 70; k++) begin
         op(0,0,0,0,0,1,1,1,"R9 long pulse train");
         op(0,0,0,0,0,1,0,1,"R9 long train low");
      end
      op(1,1,3,1,9,1,1,0,"R10 recall wins over all");
      op(0,0,0,0,0,1,0,1,"R10 low");
      op(0,1,1,1,9,1,1,1,"R10 parallel wins over write and step");
      op(0,0,0,1,33,1,1,0,"R10 write wins, pulse consumed");
      op(0,0,0,0,0,1,0,0,"R10 low");
      op(0,0,0,1,50,1,1,1,"R10 write wins over step");
      op(0,0,0,0,0,1,1,1,"R10 held scl no late step");
      op(0,0,0,0,0,0,0,0,"final idle");
      repeat (3) @(posedge clk);
      #2;
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule